// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Controller

This block gathers a vector of internal interrupt sources (32 or 64, chosen at build time) and, for each of two processor contexts, combines it with that context's own mask words. A source counts as pending for a context only when both its status bit and that context's mask bit are set. Each context has a one-bit summary output that shows whether anything is pending for it. Each context also has a request input. A request is answered in the next cycle with at most one selected source. There is no fixed priority. The search starts at a per-context rotating pointer, and after each grant the pointer moves to one past the granted source.

A small register port reads the status words and reads or writes the per-context mask words. The 32-bit words are stored in reversed order, so with two words the upper 32 sources sit in word 0. Two global operations act on a single source. Mask-clear removes the source from every context. Unmask enables the source for the contexts marked online and disables it for the offline ones. A contiguous range of internal sources carries cascaded external lines, and a grant that falls inside it is reported as an external index relative to the start of the range.

Each context's arbiter is a two-state machine. `ARB_IDLE` means no grant is on the outputs. `ARB_GRANT` means a grant is valid for this cycle. The transition `take` (request high with at least one source pending) enters `ARB_GRANT` from either state. Every other cycle is the transition `rest`, which returns to `ARB_IDLE`.

Top module: `rr_irq_ctrl`

## Requirements
- R1: For context c, source n is pending exactly when src_status[n] and that context's mask bit for n are both 1. irq_sum[c] is 1 in the same cycle whenever any source is pending for c.
- R2: Register address bit 2 selects the context, bit 1 selects the kind (0 = status, 1 = mask) and bit 0 selects the word. Reads are combinational. A write with kind 1 stores reg_wdata into that context's mask word at the next clock edge. A write with kind 0 has no effect.
- R3: Source n lives in word (n/32) XOR (WORDS-1), at bit n%32. With 64 sources, word 0 holds sources 32..63. With 32 sources, word 1 reads as zero and writes to it are ignored.
- R4: A request on a context that has something pending gives gnt_valid high for exactly the following cycle. With no request, gnt_valid stays low.
- R5: The search starts at the context's pointer and moves upward, wrapping modulo the source count. After a grant, the pointer becomes the granted source plus one, modulo the source count.
- R6: A request with nothing pending gives no grant and leaves that context's pointer unchanged.
- R7: The two contexts have separate mask words, pointers and grant outputs. Activity on one context does not change the other.
- R8: op_mask_clr clears the bit of source op_src in the masks of both contexts. It takes precedence over op_unmask in the same cycle.
- R9: op_unmask sets the bit of op_src for each context whose cpu_online bit is 1 and clears it for each context whose bit is 0.
- R10: A grant of source k with EXT_LO <= k <= EXT_HI gives gnt_ext = 1 and index k-EXT_LO. Any other grant gives gnt_ext = 0 and index k. Each context's index occupies gnt_idx[6c+5:6c].
- R11: Synchronous active-high reset clears all mask words, sets both pointers to 0 and removes any grant.
- R12: When a register mask write and a mask operation hit the same word in one cycle, the operation's effect on its own bit wins. The written value holds for all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_status | input | NUM_SRC | Raw interrupt status, one bit per source |
| cpu_online | input | 2 | Online flag per context, used by unmask |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | {context, kind, word} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data |
| op_mask_clr | input | 1 | Clear op_src in all contexts |
| op_unmask | input | 1 | Set or clear op_src according to cpu_online |
| op_src | input | 6 | Source index for the mask operations |
| irq_req | input | 2 | Grant request per context |
| irq_sum | output | 2 | Any source pending, per context |
| gnt_valid | output | 2 | Grant valid per context |
| gnt_idx | output | 12 | Reported index, 6 bits per context |
| gnt_ext | output | 2 | Grant falls in the cascaded external range |

## Verification
A pointer that is off shows up at the very next grant as the wrong source. The grant sequence over a set of pending sources exposes it within one rotation. A mask word stored in the wrong position is visible at once on the register read port, and on irq_sum in the same cycle the status changes. A fault in the remap range shows up only when a grant lands on a boundary source, so the sources on both sides of each edge of the range are granted and checked one cycle after their request.

// File: rtl/rrirq_pkg.sv
package rrirq_pkg;
    localparam int WORD_BITS = 32;
    localparam int GNT_W     = 6;

    typedef enum logic {ARB_IDLE, ARB_GRANT} arb_state_t;

    // word that holds source n, words stored in reversed order
    function automatic int word_of(input int n, input int words);
        return (n / WORD_BITS) ^ (words - 1);
    endfunction
endpackage

// File: rtl/rrirq_mask_bank.sv
module rrirq_mask_bank
    import rrirq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int WORDS  = NUM_SRC / WORD_BITS
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic                                wr_ctx,
    input  logic                                wr_word,
    input  logic [WORD_BITS-1:0]                wr_data,
    input  logic                                clr_en,
    input  logic                                set_en,
    input  logic [GNT_W-1:0]                    op_src,
    input  logic [1:0]                          online,
    output logic [1:0][WORDS-1:0][WORD_BITS-1:0] mask_q,
    output logic [1:0][NUM_SRC-1:0]             mask_src
);
    localparam logic TOP_WORD = (WORDS == 2);

    logic op_valid;
    logic op_word;

    assign op_valid = (int'(op_src) < NUM_SRC);
    assign op_word  = op_src[5] ^ TOP_WORD;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (wr_en && (wr_word == w[0]))
                    mask_q[wr_ctx][w] <= wr_data;
            end
            // operations come after the write so they win on their bit
            for (int c = 0; c < 2; c++) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (op_valid && (op_word == w[0])) begin
                        if (clr_en)
                            mask_q[c][w][op_src[4:0]] <= 1'b0;
                        else if (set_en)
                            mask_q[c][w][op_src[4:0]] <= online[c];
                    end
                end
            end
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_ctx
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            assign mask_src[c][n] = mask_q[c][word_of(n, WORDS)][n % WORD_BITS];
        end
    end

    // R8: clear reaches both contexts
    a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
        (clr_en && op_valid) |=> (!mask_src[0][$past(op_src)] && !mask_src[1][$past(op_src)]));

    // R9: unmask follows the online flags
    a_r9_unmask_online: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en && op_valid) |=>
            (mask_src[0][$past(op_src)] == $past(online[0]) &&
             mask_src[1][$past(op_src)] == $past(online[1])));

    // R11: masks are empty after reset
    a_r11_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (mask_q == '0));
endmodule

// File: rtl/rrirq_rr_pick.sv
module rrirq_rr_pick
    import rrirq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int EXT_LO  = 40,
    parameter int EXT_HI  = 43,
    parameter bit EXT_EN  = 1'b1,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [NUM_SRC-1:0] pend,
    output logic               gnt_valid,
    output logic [GNT_W-1:0]   gnt_idx,
    output logic               gnt_ext
);
    arb_state_t       state_q, state_d;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] sel;
    logic             found;
    logic             take;
    logic             in_rng;
    logic [GNT_W-1:0] mapped;

    // rotating search from the pointer
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            logic [IDX_W-1:0] k;
            k = ptr_q + IDX_W'(i);
            if (!found && pend[k]) begin
                found = 1'b1;
                sel   = k;
            end
        end
    end

    assign take   = req && found;
    assign in_rng = EXT_EN && (int'(sel) >= EXT_LO) && (int'(sel) <= EXT_HI);
    assign mapped = in_rng ? GNT_W'(int'(sel) - EXT_LO) : GNT_W'(sel);

    always_comb begin
        unique case (state_q)
            ARB_IDLE:  state_d = take ? ARB_GRANT : ARB_IDLE;
            ARB_GRANT: state_d = take ? ARB_GRANT : ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_IDLE;
        else     state_q <= state_d;
    end

    // output and pointer register
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            gnt_idx <= '0;
            gnt_ext <= 1'b0;
        end else if (take) begin
            ptr_q   <= sel + IDX_W'(1);
            gnt_idx <= mapped;
            gnt_ext <= in_rng;
        end
    end

    assign gnt_valid = (state_q == ARB_GRANT);

    // R4: a request with work pending is answered next cycle
    a_r4_req_grants: assert property (@(posedge clk) disable iff (rst)
        (req && |pend) |=> gnt_valid);

    // R4: no grant without a request
    a_r4_no_req_idle: assert property (@(posedge clk) disable iff (rst)
        !req |=> !gnt_valid);

    // R6: empty request keeps the pointer
    a_r6_empty_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        (req && !(|pend)) |=> (!gnt_valid && $stable(ptr_q)));

    // R5: pointer sits one past an internal grant
    a_r5_ptr_after_grant: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !gnt_ext) |-> (ptr_q == IDX_W'(gnt_idx + GNT_W'(1))));

    // R10: external index stays within the range width
    a_r10_ext_bound: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_ext) |-> (int'(gnt_idx) <= EXT_HI - EXT_LO));
endmodule

// File: rtl/rr_irq_ctrl.sv
module rr_irq_ctrl
    import rrirq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int EXT_LO  = 40,
    parameter int EXT_HI  = 43,
    parameter bit EXT_EN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_status,
    input  logic [1:0]         cpu_online,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               op_mask_clr,
    input  logic               op_unmask,
    input  logic [5:0]         op_src,
    input  logic [1:0]         irq_req,
    output logic [1:0]         irq_sum,
    output logic [1:0]         gnt_valid,
    output logic [11:0]        gnt_idx,
    output logic [1:0]         gnt_ext
);
    localparam int WORDS = NUM_SRC / WORD_BITS;

    logic [1:0][WORDS-1:0][WORD_BITS-1:0] mask_q;
    logic [1:0][NUM_SRC-1:0]              mask_src;
    logic [WORDS-1:0][WORD_BITS-1:0]      status_w;

    rrirq_mask_bank #(.NUM_SRC(NUM_SRC)) u_masks (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr && reg_addr[1]),
        .wr_ctx   (reg_addr[2]),
        .wr_word  (reg_addr[0]),
        .wr_data  (reg_wdata),
        .clr_en   (op_mask_clr),
        .set_en   (op_unmask),
        .op_src   (op_src),
        .online   (cpu_online),
        .mask_q   (mask_q),
        .mask_src (mask_src)
    );

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_stat
        assign status_w[word_of(n, WORDS)][n % WORD_BITS] = src_status[n];
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (reg_addr[0] == w[0])
                reg_rdata = reg_addr[1] ? mask_q[reg_addr[2]][w] : status_w[w];
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_arb
        logic [NUM_SRC-1:0] pend;
        assign pend       = src_status & mask_src[c];
        assign irq_sum[c] = |pend;

        rrirq_rr_pick #(
            .NUM_SRC (NUM_SRC),
            .EXT_LO  (EXT_LO),
            .EXT_HI  (EXT_HI),
            .EXT_EN  (EXT_EN)
        ) u_pick (
            .clk       (clk),
            .rst       (rst),
            .req       (irq_req[c]),
            .pend      (pend),
            .gnt_valid (gnt_valid[c]),
            .gnt_idx   (gnt_idx[c*GNT_W +: GNT_W]),
            .gnt_ext   (gnt_ext[c])
        );
    end

    // R1: summary and grant agree for context 0
    a_r1_sum_grant: assert property (@(posedge clk) disable iff (rst)
        (irq_req[0] && irq_sum[0]) |=> gnt_valid[0]);

    // R7: a request on context 1 alone never grants context 0
    a_r7_ctx_apart: assert property (@(posedge clk) disable iff (rst)
        (irq_req == 2'b10) |=> !gnt_valid[0]);
endmodule

// File: tb/rr_irq_ctrl_tb.sv
module rr_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic [63:0] src_status = '0;
    logic [1:0]  cpu_online = 2'b11;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        op_mask_clr = 0, op_unmask = 0;
    logic [5:0]  op_src = '0;
    logic [1:0]  irq_req = '0;
    logic [1:0]  irq_sum, gnt_valid, gnt_ext;
    logic [11:0] gnt_idx;

    rr_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .src_status(src_status), .cpu_online(cpu_online),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .op_mask_clr(op_mask_clr), .op_unmask(op_unmask), .op_src(op_src),
        .irq_req(irq_req), .irq_sum(irq_sum), .gnt_valid(gnt_valid),
        .gnt_idx(gnt_idx), .gnt_ext(gnt_ext)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { bit v; int idx; bit ext; string tag; } exp_t;
    exp_t q0[$];
    exp_t q1[$];

    int total = 0, bad = 0;
    bit [63:0] mm[2];
    int mp[2];

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t model_pick(input int c, input string tag);
        exp_t e;
        bit [63:0] p;
        p = src_status & mm[c];
        e.v = 0; e.idx = 0; e.ext = 0; e.tag = tag;
        for (int i = 0; i < 64; i++) begin
            int k;
            k = (mp[c] + i) % 64;
            if (!e.v && p[k]) begin
                e.v = 1;
                e.ext = (k >= 40 && k <= 43);
                e.idx = e.ext ? k - 40 : k;
                mp[c] = (k + 1) % 64;
            end
        end
        return e;
    endfunction

    // driver: raise requests and push expected grants
    task automatic req_ctx(input bit r0, input bit r1, input string tag);
        @(negedge clk);
        if (r0) q0.push_back(model_pick(0, tag));
        if (r1) q1.push_back(model_pick(1, tag));
        irq_req = {r1, r0};
        @(negedge clk);
        irq_req = 2'b00;
    endtask

    // monitor: compare grants one cycle after the request
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                for (int c = 0; c < 2; c++) begin
                    exp_t e;
                    bit have;
                    have = (c == 0) ? (q0.size() > 0) : (q1.size() > 0);
                    if (have) begin
                        e = (c == 0) ? q0.pop_front() : q1.pop_front();
                        chk($sformatf("%s valid ctx%0d", e.tag, c), gnt_valid[c], e.v);
                        if (e.v) begin
                            chk($sformatf("%s idx ctx%0d", e.tag, c), gnt_idx[c*6 +: 6], e.idx);
                            chk($sformatf("%s ext ctx%0d", e.tag, c), gnt_ext[c], e.ext);
                        end
                    end else if (gnt_valid[c] !== 1'b0) begin
                        chk($sformatf("R4 spurious ctx%0d", c), gnt_valid[c], 0);
                    end
                end
            end
        end
    end

    task automatic mw(input int c, input int w, input logic [31:0] d, input bit op_clr0);
        @(negedge clk);
        reg_wr = 1; reg_addr = {c[0], 1'b1, w[0]}; reg_wdata = d;
        if (op_clr0) begin op_mask_clr = 1; op_src = 6'd0; end
        for (int b = 0; b < 32; b++) mm[c][((w ^ 1) * 32) + b] = d[b];
        if (op_clr0) begin mm[0][0] = 0; mm[1][0] = 0; end
        @(negedge clk);
        reg_wr = 0; op_mask_clr = 0;
    endtask

    task automatic status_wr(input int w, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = {1'b0, 1'b0, w[0]}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic op(input bit clr, input bit set, input int s);
        @(negedge clk);
        op_mask_clr = clr; op_unmask = set; op_src = s[5:0];
        for (int c = 0; c < 2; c++) begin
            if (clr) mm[c][s] = 0;
            else if (set) mm[c][s] = cpu_online[c];
        end
        @(negedge clk);
        op_mask_clr = 0; op_unmask = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        mm[0] = '0; mm[1] = '0; mp[0] = 0; mp[1] = 0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        do_reset();
        // R11 reset state
        for (int a = 0; a < 4; a++) rd({a[1], 1'b1, a[0]}, 32'h0, "R11 mask zero after reset");
        chk("R11 no grant after reset", gnt_valid, 0);
        chk("R11 no summary after reset", irq_sum, 0);

        // R3 reversed words, R1 pending and summary, R7 contexts apart
        mw(0, 0, 32'h1, 0);
        @(negedge clk); src_status = 64'h1_0000_0000;
        #1;
        chk("R1 summary ctx0", irq_sum[0], 1);
        chk("R7 summary ctx1 idle", irq_sum[1], 0);
        rd(3'b000, 32'h1, "R3 source 32 in word 0");
        rd(3'b001, 32'h0, "R3 word 1 empty");
        mw(0, 1, 32'h11, 0);
        @(negedge clk); src_status = 64'h1_0000_0011;
        rd(3'b001, 32'h11, "R3 sources 0 and 4 in word 1");

        // R5 rotation with wrap
        req_ctx(1, 0, "R5 rr first");
        req_ctx(1, 0, "R5 rr second");
        req_ctx(1, 0, "R5 rr third");
        req_ctx(1, 0, "R5 rr wrap");

        // R6 empty request keeps pointer
        @(negedge clk); src_status = '0;
        req_ctx(1, 0, "R6 empty no grant");
        @(negedge clk); src_status = 64'h11;
        req_ctx(1, 0, "R6 pointer kept");

        // R9 unmask both online, R7 separate pointers
        cpu_online = 2'b11;
        op(0, 1, 4);
        req_ctx(1, 1, "R7 both contexts");
        rd(3'b111, 32'h10, "R9 unmask online ctx1");

        // R9 offline context cleared
        mw(1, 1, 32'h1, 0);
        cpu_online = 2'b01;
        op(0, 1, 0);
        rd(3'b111, 32'h0, "R9 offline ctx1 cleared");
        rd(3'b011, 32'h11, "R9 online ctx0 set");

        // R8 clear hits both contexts
        mw(1, 1, 32'h10, 0);
        op(1, 0, 4);
        rd(3'b011, 32'h1, "R8 cleared ctx0");
        rd(3'b111, 32'h0, "R8 cleared ctx1");

        // R10 remap at range edges
        mw(0, 0, 32'h1980, 0);
        @(negedge clk); src_status = (64'h1 << 39) | (64'h1 << 40) | (64'h1 << 43) | (64'h1 << 44);
        req_ctx(1, 0, "R10 below range");
        req_ctx(1, 0, "R10 range start");
        req_ctx(1, 0, "R10 range end");
        req_ctx(1, 0, "R10 above range");
        req_ctx(1, 0, "R10 wrap again");
        chk("R1 ctx1 nothing enabled", irq_sum[1], 0);

        // R2 status writes ignored
        status_wr(0, 32'hFFFF_FFFF);
        rd(3'b000, 32'h1980, "R2 status unchanged");
        rd(3'b010, 32'h1980, "R2 mask unchanged");

        // R12 op wins over write
        mw(0, 1, 32'hFFFF_FFFF, 1);
        rd(3'b011, 32'hFFFF_FFFE, "R12 op over write");

        // R11 reset restarts pointers
        @(negedge clk); src_status = 64'h11;
        do_reset();
        rd(3'b011, 32'h0, "R11 mask cleared again");
        mw(0, 1, 32'h11, 0);
        req_ctx(1, 0, "R11 pointer from zero");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule